// File: doc/BRIEF.md
# Fault Summary Register

This block keeps an 8-bit fault summary for a serially controlled data converter. Event pulses and level inputs from neighbouring logic set individual sticky fault bits. These sources are the command decoder, the lock state, the watchdog, the resync logic, the output shifter and the input integrity checkers. Two bits are summaries: each is the OR of a lower-level status register.

Each bit has its own clearing trigger. Four bits clear when this register is read. The integrity-check bit and the serial-status summary clear when the serial-interface status register is read. The input-fault summary clears only after both the positive-input and negative-input fault registers have been read. When a setting event and its clearing read fall in the same cycle, the set wins. The output `rd_data` always shows the register, so a read returns the value the register held before that read clears it.

Top module: `fault_summary_reg`

## Requirements
- R1: Bit 7 of `rd_data` reads 0 at all times, and `rd_data[6:0]` shows the fault register as it stands in that cycle.
- R2: A command accepted with `cmd_valid`=1 and `cmd_known`=0 sets bit 6 on the next clock edge.
- R3: While `locked`=1, a known command sets bit 6 unless `cmd_code` is one of the allowed codes. The allowed codes are 0 (null), 1 (register read), 3 (lock) and 4 (unlock); codes 2, 5, 6 and 7 set the bit. While `locked`=0, a known command never sets bit 6.
- R4: A cycle with `rd_en`=1 clears bits 6, 3, 2 and 1 at that cycle's clock edge, and `rd_data` still shows them as set during that cycle. If a bit's set event occurs in the same cycle, that bit stays 1.
- R5: Bit 5 sets when `spi_stat` is nonzero. A cycle with `spi_stat_rd`=1 clears bit 5, and that same cycle's `spi_stat` is ignored. If `spi_stat` is still nonzero one cycle later, bit 5 sets again.
- R6: Bit 4 sets when `pos_stat` or `neg_stat` is nonzero. Bit 4 clears only after both `pos_rd` and `neg_rd` have been seen while it is 1, in any order or together. The status levels are ignored in the cycle that completes the pair.
- R7: `wdt_expire` sets bit 3.
- R8: `resync_evt` sets bit 2 only while `sync_slave`=1, and has no effect otherwise.
- R9: `drdy_new` sets bit 1 only while `dout_busy`=1.
- R10: Bit 0 sets on `crc_fail`, or on `ham_uncorr` while `ham_en`=1. Bit 0 clears on `spi_stat_rd` and not on `rd_en`, and the set wins in the same cycle.
- R11: With `rst_n`=0 at a clock edge, every bit and the pair-read tracking return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Pulse: a command was received |
| cmd_known | input | 1 | The received opcode decoded as valid |
| cmd_code | input | 3 | Command class (0 null, 1 read, 2 write, 3 lock, 4 unlock, 5-7 other) |
| locked | input | 1 | Device is in the locked state |
| wdt_expire | input | 1 | Pulse: watchdog expired before a new frame |
| sync_slave | input | 1 | Synchronous slave mode is selected |
| resync_evt | input | 1 | Pulse: signal path was reset to resynchronise |
| drdy_new | input | 1 | Pulse: new conversion data ready |
| dout_busy | input | 1 | Previous result is still being shifted out |
| ham_en | input | 1 | Hamming protection is enabled |
| ham_uncorr | input | 1 | Pulse: uncorrectable Hamming error on an input word |
| crc_fail | input | 1 | Pulse: input CRC word mismatched |
| spi_stat | input | SPI_W | Serial-interface status register contents |
| spi_stat_rd | input | 1 | Pulse: serial-interface status register is being read |
| pos_stat | input | PN_W | Positive-input fault register contents |
| neg_stat | input | PN_W | Negative-input fault register contents |
| pos_rd | input | 1 | Pulse: positive-input fault register is being read |
| neg_rd | input | 1 | Pulse: negative-input fault register is being read |
| rd_en | input | 1 | Pulse: this register is being read |
| rd_data | output | 8 | Fault register contents |

## Verification
The hardest situations to reach are those where a clearing read and a fresh set land in the same cycle. Another is the input-fault bit after only one of its two reads has been seen. A third is the serial-status summary when the lower register is still nonzero after its read. Directed sequences place `rd_en` together with `wdt_expire` and `spi_stat_rd` together with `crc_fail`. They split `pos_rd` and `neg_rd` across separate cycles and hold `spi_stat` high across a read. A long random phase then mixes every pulse, level and read at low rates against the bench's behavioural model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int CODE_W = 3;
  localparam int NFLAG  = 7;

  localparam int B_CHECK  = 0;
  localparam int B_OVRUN  = 1;
  localparam int B_RESYNC = 2;
  localparam int B_WDOG   = 3;
  localparam int B_INPUT  = 4;
  localparam int B_SERIAL = 5;
  localparam int B_CMD    = 6;

  typedef enum logic [CODE_W-1:0] {
    CMD_NULL   = 3'd0,
    CMD_RREG   = 3'd1,
    CMD_WREG   = 3'd2,
    CMD_LOCK   = 3'd3,
    CMD_UNLOCK = 3'd4,
    CMD_X5     = 3'd5,
    CMD_X6     = 3'd6,
    CMD_X7     = 3'd7
  } cmd_code_e;

  function automatic logic allowed_when_locked(input logic [CODE_W-1:0] code);
    return (code == CMD_NULL) || (code == CMD_RREG) ||
           (code == CMD_LOCK) || (code == CMD_UNLOCK);
  endfunction
endpackage

// File: rtl/fsr_cmd_screen.sv
module fsr_cmd_screen
  import fsr_pkg::*;
(
  input  logic              cmd_valid,
  input  logic              cmd_known,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              locked,
  output logic              cmd_fault
);
  logic lock_reject;

  always_comb begin
    lock_reject = locked && !allowed_when_locked(cmd_code);
    cmd_fault   = cmd_valid && (!cmd_known || lock_reject);
  end
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/fsr_pair_clear.sv
module fsr_pair_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rd_a,
  input  logic rd_b,
  output logic done
);
  logic seen_a, seen_b;

  assign done = active && (seen_a || rd_a) && (seen_b || rd_b);

  always_ff @(posedge clk) begin
    if (!rst_n || !active || done) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      seen_a <= seen_a || rd_a;
      seen_b <= seen_b || rd_b;
    end
  end
endmodule

// File: rtl/fault_summary_reg.sv
module fault_summary_reg
  import fsr_pkg::*;
#(
  parameter int SPI_W = 8,
  parameter int PN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_known,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              locked,
  input  logic              wdt_expire,
  input  logic              sync_slave,
  input  logic              resync_evt,
  input  logic              drdy_new,
  input  logic              dout_busy,
  input  logic              ham_en,
  input  logic              ham_uncorr,
  input  logic              crc_fail,
  input  logic [SPI_W-1:0]  spi_stat,
  input  logic              spi_stat_rd,
  input  logic [PN_W-1:0]   pos_stat,
  input  logic [PN_W-1:0]   neg_stat,
  input  logic              pos_rd,
  input  logic              neg_rd,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);
  logic [NFLAG-1:0] set_v, clr_v, flags;
  logic             cmd_fault, input_done;

  fsr_cmd_screen u_screen (
    .cmd_valid (cmd_valid),
    .cmd_known (cmd_known),
    .cmd_code  (cmd_code),
    .locked    (locked),
    .cmd_fault (cmd_fault)
  );

  fsr_pair_clear u_pair (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (flags[B_INPUT]),
    .rd_a   (pos_rd),
    .rd_b   (neg_rd),
    .done   (input_done)
  );

  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[B_CHECK]  = crc_fail || (ham_en && ham_uncorr);
    clr_v[B_CHECK]  = spi_stat_rd;
    set_v[B_OVRUN]  = drdy_new && dout_busy;
    clr_v[B_OVRUN]  = rd_en;
    set_v[B_RESYNC] = resync_evt && sync_slave;
    clr_v[B_RESYNC] = rd_en;
    set_v[B_WDOG]   = wdt_expire;
    clr_v[B_WDOG]   = rd_en;
    set_v[B_INPUT]  = ((|pos_stat) || (|neg_stat)) && !input_done;
    clr_v[B_INPUT]  = input_done;
    set_v[B_SERIAL] = (|spi_stat) && !spi_stat_rd;
    clr_v[B_SERIAL] = spi_stat_rd;
    set_v[B_CMD]    = cmd_fault;
    clr_v[B_CMD]    = rd_en;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    fsr_sticky u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v[i]),
      .clr   (clr_v[i]),
      .q     (flags[i])
    );
  end

  assign rd_data = {1'b0, flags};
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_known,
  input logic [2:0] cmd_code,
  input logic       locked,
  input logic       wdt_expire,
  input logic       sync_slave,
  input logic       resync_evt,
  input logic       crc_fail,
  input logic       ham_en,
  input logic       ham_uncorr,
  input logic       spi_stat_rd,
  input logic       pos_rd,
  input logic       neg_rd,
  input logic       rd_en,
  input logic [7:0] rd_data
);
  always_comb begin
    if (rst_n) p_reserved_zero_r1: assert (rd_data[7] == 1'b0);
  end

  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_known |=> rd_data[6]);

  p_lock_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_known && locked &&
    !(cmd_code == 3'd0 || cmd_code == 3'd1 || cmd_code == 3'd3 || cmd_code == 3'd4)
    |=> rd_data[6]);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wdt_expire |=> !rd_data[3]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> rd_data[3]);

  p_serial_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_stat_rd |=> !rd_data[5]);

  p_pair_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_rd && neg_rd && rd_data[4] |=> !rd_data[4]);

  p_resync_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] && !(resync_evt && sync_slave) |=> !rd_data[2]);

  p_check_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_stat_rd && !crc_fail && !(ham_en && ham_uncorr) |=> !rd_data[0]);
endmodule

bind fault_summary_reg fsr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_known   (cmd_known),
  .cmd_code    (cmd_code),
  .locked      (locked),
  .wdt_expire  (wdt_expire),
  .sync_slave  (sync_slave),
  .resync_evt  (resync_evt),
  .crc_fail    (crc_fail),
  .ham_en      (ham_en),
  .ham_uncorr  (ham_uncorr),
  .spi_stat_rd (spi_stat_rd),
  .pos_rd      (pos_rd),
  .neg_rd      (neg_rd),
  .rd_en       (rd_en),
  .rd_data     (rd_data)
);

// File: tb/fault_summary_reg_bench.sv
`timescale 1ns/1ps
module fault_summary_reg_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 0, cmd_known = 0, locked = 0;
  logic [2:0] cmd_code = 0;
  logic       wdt_expire = 0, sync_slave = 0, resync_evt = 0;
  logic       drdy_new = 0, dout_busy = 0, ham_en = 0, ham_uncorr = 0, crc_fail = 0;
  logic [7:0] spi_stat = 0, pos_stat = 0, neg_stat = 0;
  logic       spi_stat_rd = 0, pos_rd = 0, neg_rd = 0, rd_en = 0;
  logic [7:0] rd_data;

  fault_summary_reg u_fault_summary_reg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_known(cmd_known),
    .cmd_code(cmd_code), .locked(locked), .wdt_expire(wdt_expire),
    .sync_slave(sync_slave), .resync_evt(resync_evt), .drdy_new(drdy_new),
    .dout_busy(dout_busy), .ham_en(ham_en), .ham_uncorr(ham_uncorr),
    .crc_fail(crc_fail), .spi_stat(spi_stat), .spi_stat_rd(spi_stat_rd),
    .pos_stat(pos_stat), .neg_stat(neg_stat), .pos_rd(pos_rd), .neg_rd(neg_rd),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference: one integer per fault bit
  int m [8];
  bit seen_p = 0, seen_n = 0;

  always @(posedge clk) begin
    int nx [8];
    bit allowed, pair;
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      seen_p = 0; seen_n = 0;
    end else begin
      nx = m;
      allowed = (cmd_code inside {3'd0, 3'd1, 3'd3, 3'd4});
      if (rd_en) begin nx[6] = 0; nx[3] = 0; nx[2] = 0; nx[1] = 0; end
      if (cmd_valid && (!cmd_known || (locked && !allowed))) nx[6] = 1;
      if (wdt_expire) nx[3] = 1;
      if (resync_evt && sync_slave) nx[2] = 1;
      if (drdy_new && dout_busy) nx[1] = 1;
      if (spi_stat_rd) begin nx[0] = 0; nx[5] = 0; end
      else if (spi_stat != 0) nx[5] = 1;
      if (crc_fail || (ham_en && ham_uncorr)) nx[0] = 1;
      pair = (m[4] == 1) && (seen_p || pos_rd) && (seen_n || neg_rd);
      if (pair) begin
        nx[4] = 0; seen_p = 0; seen_n = 0;
      end else begin
        if (m[4] == 1) begin
          seen_p = seen_p || pos_rd;
          seen_n = seen_n || neg_rd;
        end else begin
          seen_p = 0; seen_n = 0;
        end
        if (pos_stat != 0 || neg_stat != 0) nx[4] = 1;
      end
      m = nx;
    end
  end

  function automatic string tag_of(int b);
    case (b)
      7: return "R1"; 6: return "R2"; 5: return "R5"; 4: return "R6";
      3: return "R7"; 2: return "R8"; 1: return "R9"; default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int b = 0; b < 8; b++) begin
        checks++;
        if (rd_data[b] !== m[b][0]) begin
          errors++;
          $display("FAIL %s model bit %0d: actual %0b expected %0b",
                   tag_of(b), b, rd_data[b], m[b][0]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet;
    cmd_valid = 0; cmd_known = 0; wdt_expire = 0; resync_evt = 0; drdy_new = 0;
    ham_uncorr = 0; crc_fail = 0; spi_stat_rd = 0; pos_rd = 0; neg_rd = 0; rd_en = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R11 reset: actual %h expected 00", rd_data);
    end
    rst_n = 1;

    // R2 invalid opcode, R4 read returns old value then clears
    cmd_valid = 1; cmd_known = 0; tick(); quiet();
    chk("R2", rd_data[6], 1);
    rd_en = 1; chk("R4 pre-clear", rd_data[6], 1); tick(); quiet();
    chk("R4", rd_data[6], 0);

    // R3 lock whitelist
    locked = 1; cmd_valid = 1; cmd_known = 1; cmd_code = 3'd2; tick(); quiet();
    chk("R3 locked write", rd_data[6], 1);
    rd_en = 1; tick(); quiet();
    cmd_valid = 1; cmd_known = 1; cmd_code = 3'd1; tick(); quiet();
    chk("R3 locked read", rd_data[6], 0);
    cmd_valid = 1; cmd_known = 1; cmd_code = 3'd4; tick(); quiet();
    chk("R3 locked unlock", rd_data[6], 0);
    locked = 0; cmd_valid = 1; cmd_known = 1; cmd_code = 3'd2; tick(); quiet();
    chk("R3 unlocked write", rd_data[6], 0);

    // R7 watchdog, R4 set wins
    wdt_expire = 1; tick(); quiet();
    chk("R7", rd_data[3], 1);
    wdt_expire = 1; rd_en = 1; tick(); quiet();
    chk("R4 set wins", rd_data[3], 1);
    rd_en = 1; tick(); quiet();
    chk("R4 wdog clear", rd_data[3], 0);

    // R8 resync gated by mode
    resync_evt = 1; tick(); quiet();
    chk("R8 ignored", rd_data[2], 0);
    sync_slave = 1; resync_evt = 1; tick(); quiet();
    chk("R8", rd_data[2], 1);
    rd_en = 1; tick(); quiet(); sync_slave = 0;

    // R9 overrun
    drdy_new = 1; tick(); quiet();
    chk("R9 idle", rd_data[1], 0);
    dout_busy = 1; drdy_new = 1; tick(); quiet(); dout_busy = 0;
    chk("R9", rd_data[1], 1);
    rd_en = 1; tick(); quiet();

    // R10 check fault
    ham_uncorr = 1; tick(); quiet();
    chk("R10 ham off", rd_data[0], 0);
    ham_en = 1; ham_uncorr = 1; tick(); quiet();
    chk("R10 ham", rd_data[0], 1);
    rd_en = 1; tick(); quiet();
    chk("R10 own read", rd_data[0], 1);
    spi_stat_rd = 1; crc_fail = 1; tick(); quiet();
    chk("R10 set wins", rd_data[0], 1);
    spi_stat_rd = 1; tick(); quiet();
    chk("R10 clear", rd_data[0], 0);

    // R5 serial summary
    spi_stat = 8'h04; tick();
    chk("R5", rd_data[5], 1);
    spi_stat_rd = 1; tick(); quiet(); spi_stat = 0; tick();
    chk("R5 clear", rd_data[5], 0);
    spi_stat = 8'h10; tick();
    spi_stat_rd = 1; tick(); quiet();
    chk("R5 gap", rd_data[5], 0);
    tick();
    chk("R5 persists", rd_data[5], 1);
    spi_stat = 0; spi_stat_rd = 1; tick(); quiet();

    // R6 pair of reads
    pos_stat = 8'h01; tick();
    chk("R6", rd_data[4], 1);
    pos_rd = 1; tick(); quiet(); pos_stat = 0; tick();
    chk("R6 one read", rd_data[4], 1);
    neg_rd = 1; tick(); quiet();
    chk("R6 both read", rd_data[4], 0);
    chk("R1", rd_data[7], 0);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      cmd_valid   = ($urandom % 6) == 0;
      cmd_known   = ($urandom % 3) != 0;
      cmd_code    = 3'($urandom);
      locked      = ($urandom % 2) == 0;
      wdt_expire  = ($urandom % 12) == 0;
      sync_slave  = ($urandom % 2) == 0;
      resync_evt  = ($urandom % 8) == 0;
      drdy_new    = ($urandom % 5) == 0;
      dout_busy   = ($urandom % 2) == 0;
      ham_en      = ($urandom % 2) == 0;
      ham_uncorr  = ($urandom % 10) == 0;
      crc_fail    = ($urandom % 14) == 0;
      if (($urandom % 7) == 0) spi_stat = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      if (($urandom % 7) == 0) pos_stat = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      if (($urandom % 7) == 0) neg_stat = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      spi_stat_rd = ($urandom % 6) == 0;
      pos_rd      = ($urandom % 5) == 0;
      neg_rd      = ($urandom % 5) == 0;
      rd_en       = ($urandom % 4) == 0;
      tick();
    end
    quiet();
    tick();
    finish_run();
  end
endmodule